// File: doc/BRIEF.md
# Parallel 8080-style LCD Write-Cycle Sequencer

This block turns one host write request into one write cycle on an 8080-style parallel bus to an LCD panel. The host offers a command/data select bit and a data word under a valid/ready handshake. The block then drives the select line, an active-low chip select, an active-low write strobe, the data word and a data output-enable.

Four phases frame each cycle, and each phase lasts its programmed value plus one clock:
- address-to-select setup, which ends when chip select falls;
- select-to-strobe setup, which ends when the write strobe falls;
- strobe width, which ends when the write strobe rises;
- strobe-to-release hold, which ends when chip select rises.

The four phase values are configuration inputs. The block samples them on the cycle it accepts a request, so the host may change them while a cycle is running. A host that holds its valid high gets back-to-back cycles with a single idle clock between them.

Top module: `i80_write_seq`

## Requirements
- R1: While idle, and after any clock edge with rst_n low, the outputs are lcd_cs_n=1, lcd_wr_n=1, lcd_oe=0, busy=0 and in_ready=1.
- R2: A request is accepted on a rising clock edge where in_valid and in_ready are both 1. in_ready is 1 only while idle. busy is 1 from the cycle after acceptance until chip select returns high.
- R3: lcd_cs_n falls cs_setup+1 cycles after busy first reads 1.
- R4: lcd_wr_n falls wr_setup+1 cycles after lcd_cs_n falls.
- R5: lcd_wr_n stays low for exactly wr_active+1 cycles.
- R6: lcd_cs_n rises wr_hold+1 cycles after lcd_wr_n rises, and busy falls on that same edge.
- R7: lcd_oe is 0 before the write strobe falls. It is 1 from the fall of lcd_wr_n until lcd_cs_n rises. Throughout that window lcd_data equals the accepted word and does not change.
- R8: lcd_rs equals the accepted select bit (1 = data, 0 = command) on every busy cycle, and does not change during the transfer.
- R9: The four 4-bit phase fields, in_rs and in_data are sampled only at acceptance. Changes to them during a transfer do not alter that transfer's timing, select bit or data.
- R10: With in_valid held high, the next transfer is accepted on the edge right after chip select rises. busy therefore reads 0 for exactly one cycle between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock; all phases are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a write request |
| in_ready | output | 1 | Block is idle and will take a request |
| in_rs | input | 1 | Select bit of the request (1 = data, 0 = command) |
| in_data | input | DW (16) | Data word of the request |
| cfg_cs_setup | input | CW (4) | Address-to-select setup length minus one |
| cfg_wr_setup | input | CW (4) | Select-to-strobe setup length minus one |
| cfg_wr_active | input | CW (4) | Strobe low width minus one |
| cfg_wr_hold | input | CW (4) | Strobe-to-release hold length minus one |
| lcd_rs | output | 1 | Select (address) line to the panel |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_data | output | DW (16) | Data bus value |
| lcd_oe | output | 1 | Data bus output-enable |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps every value of each phase field with the other fields at zero, and also runs the all-zero and all-fifteen settings. A phase counter with an off-by-one, whether it uses value or value+2, or one that terminates early at zero, shows up as a wrong edge distance. A batch of random back-to-back transfers scrambles the configuration, select bit and data right after each acceptance. A design that reads its fields live, rather than latching them, would then stretch phases or emit the wrong word. The batch also checks that the idle gap between transfers is exactly one clock. A final reset during the longest transfer must return every strobe to idle at once.

// File: rtl/i80_seq_pkg.sv
// Shared definitions for the 8080-style write sequencer.
// Assumes one phase is active at a time and the encoding is private to the block.
package i80_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_CS_SETUP  = 3'd1,
        PH_WR_SETUP  = 3'd2,
        PH_WR_ACTIVE = 3'd3,
        PH_WR_HOLD   = 3'd4
    } phase_t;

endpackage

// File: rtl/i80_phase_timer.sv
// Phase length down-counter.
// A load writes the phase value. Each later cycle decrements the count
// until it reaches zero. done is high in the last cycle of a phase, so a
// phase loaded with N lasts N+1 cycles.
// Assumes load is asserted exactly on the edge that enters a phase.
module i80_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] count_q;

    // Load on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Terminal count marks the final cycle of the current phase.
    always_comb begin
        done = (count_q == '0);
    end

endmodule

// File: rtl/i80_phase_fsm.sv
// Phase sequencer: idle, address setup, strobe setup, strobe active, hold.
// Leaves idle on acceptance and steps one phase each time the timer
// reports done. Assumes done is valid in every non-idle cycle.
module i80_phase_fsm
    import i80_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   done,
    output phase_t phase,
    output phase_t phase_next,
    output logic   phase_load
);

    phase_t phase_q;

    // Next-phase selection from the current phase and the timer.
    always_comb begin
        phase_next = phase_q;
        unique case (phase_q)
            PH_IDLE:      if (accept) phase_next = PH_CS_SETUP;
            PH_CS_SETUP:  if (done)   phase_next = PH_WR_SETUP;
            PH_WR_SETUP:  if (done)   phase_next = PH_WR_ACTIVE;
            PH_WR_ACTIVE: if (done)   phase_next = PH_WR_HOLD;
            PH_WR_HOLD:   if (done)   phase_next = PH_IDLE;
            default:                  phase_next = PH_IDLE;
        endcase
    end

    // The timer reloads on every step into a counted phase.
    always_comb begin
        phase_load = (phase_next != phase_q) && (phase_next != PH_IDLE);
    end

    // Phase register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_next;
    end

    // Expose the registered phase.
    always_comb begin
        phase = phase_q;
    end

endmodule

// File: rtl/i80_xfer_latch.sv
// Request capture register.
// Holds the select bit, data word and the three later phase lengths from
// the accepted request for the whole transfer. The first phase length is
// used straight from the input on the accepting edge, so it is not stored.
// The held lengths reset to a setup of 0, a strobe width of 1 and a hold of 0.
module i80_xfer_latch #(
    parameter int DW = 16,
    parameter int CW = 4,
    parameter logic [CW-1:0] RST_WR_SETUP  = '0,
    parameter logic [CW-1:0] RST_WR_ACTIVE = CW'(1),
    parameter logic [CW-1:0] RST_WR_HOLD   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          in_rs,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] in_wr_setup,
    input  logic [CW-1:0] in_wr_active,
    input  logic [CW-1:0] in_wr_hold,
    output logic          held_rs,
    output logic [DW-1:0] held_data,
    output logic [CW-1:0] held_wr_setup,
    output logic [CW-1:0] held_wr_active,
    output logic [CW-1:0] held_wr_hold
);

    // Take a snapshot of the request only on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_rs        <= 1'b0;
            held_data      <= '0;
            held_wr_setup  <= RST_WR_SETUP;
            held_wr_active <= RST_WR_ACTIVE;
            held_wr_hold   <= RST_WR_HOLD;
        end else if (capture) begin
            held_rs        <= in_rs;
            held_data      <= in_data;
            held_wr_setup  <= in_wr_setup;
            held_wr_active <= in_wr_active;
            held_wr_hold   <= in_wr_hold;
        end
    end

endmodule

// File: rtl/i80_write_seq.sv
// 8080-style parallel LCD write-cycle sequencer (top).
// Accepts one request per transfer and frames the write strobe with four
// programmable phases, each lasting its value plus one clock. Bus strobes
// are decoded from the registered phase.
// Assumes clk is the internal video clock and the panel samples on the
// rising strobe.
module i80_write_seq
    import i80_seq_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_rs,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] cfg_cs_setup,
    input  logic [CW-1:0] cfg_wr_setup,
    input  logic [CW-1:0] cfg_wr_active,
    input  logic [CW-1:0] cfg_wr_hold,
    output logic          lcd_rs,
    output logic          lcd_cs_n,
    output logic          lcd_wr_n,
    output logic [DW-1:0] lcd_data,
    output logic          lcd_oe,
    output logic          busy
);

    phase_t        phase;
    phase_t        phase_next;
    logic          phase_load;
    logic          timer_done;
    logic          accept;
    logic [CW-1:0] load_val;
    logic [CW-1:0] held_wr_setup;
    logic [CW-1:0] held_wr_active;
    logic [CW-1:0] held_wr_hold;

    // Handshake: ready only while idle.
    always_comb begin
        in_ready = (phase == PH_IDLE);
        accept   = in_valid && in_ready;
    end

    // Length of the phase being entered: the first comes from the live input.
    always_comb begin
        unique case (phase_next)
            PH_CS_SETUP:  load_val = cfg_cs_setup;
            PH_WR_SETUP:  load_val = held_wr_setup;
            PH_WR_ACTIVE: load_val = held_wr_active;
            PH_WR_HOLD:   load_val = held_wr_hold;
            default:      load_val = '0;
        endcase
    end

    i80_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .done       (timer_done),
        .phase      (phase),
        .phase_next (phase_next),
        .phase_load (phase_load)
    );

    i80_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (load_val),
        .done     (timer_done)
    );

    i80_xfer_latch #(.DW(DW), .CW(CW)) u_latch (
        .clk            (clk),
        .rst_n          (rst_n),
        .capture        (accept),
        .in_rs          (in_rs),
        .in_data        (in_data),
        .in_wr_setup    (cfg_wr_setup),
        .in_wr_active   (cfg_wr_active),
        .in_wr_hold     (cfg_wr_hold),
        .held_rs        (lcd_rs),
        .held_data      (lcd_data),
        .held_wr_setup  (held_wr_setup),
        .held_wr_active (held_wr_active),
        .held_wr_hold   (held_wr_hold)
    );

    // Bus strobe decode from the registered phase.
    always_comb begin
        busy     = (phase != PH_IDLE);
        lcd_cs_n = !((phase == PH_WR_SETUP) || (phase == PH_WR_ACTIVE) ||
                     (phase == PH_WR_HOLD));
        lcd_wr_n = (phase != PH_WR_ACTIVE);
        lcd_oe   = (phase == PH_WR_ACTIVE) || (phase == PH_WR_HOLD);
    end

endmodule

// File: rtl/i80_seq_checker.sv
// Protocol checker for the write sequencer, bound to every instance of the top.
// Relates the handshake and the bus strobes over time.
module i80_seq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          lcd_rs,
    input logic          lcd_cs_n,
    input logic          lcd_wr_n,
    input logic [DW-1:0] lcd_data,
    input logic          lcd_oe,
    input logic          busy
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_cs_n && lcd_wr_n && !lcd_oe));

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != busy);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> lcd_cs_n);

    p_cs_before_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_cs_n) |-> lcd_wr_n);

    p_wr_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> !lcd_cs_n);

    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> ($past(lcd_wr_n) && !busy));

    p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> lcd_oe);

    p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_oe && $past(lcd_oe)) |-> $stable(lcd_data));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lcd_rs));

endmodule

bind i80_write_seq i80_seq_checker #(.DW(DW)) u_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .lcd_rs   (lcd_rs),
    .lcd_cs_n (lcd_cs_n),
    .lcd_wr_n (lcd_wr_n),
    .lcd_data (lcd_data),
    .lcd_oe   (lcd_oe),
    .busy     (busy)
);

// File: tb/test_i80_write_seq.sv
// Bench for the write sequencer.
// Sweeps each phase field, runs the corner settings and random
// back-to-back traffic, and measures edge distances at the negative clock edge.
module test_i80_write_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int NX = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_rs = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] cfg_cs_setup = '0;
    logic [CW-1:0] cfg_wr_setup = '0;
    logic [CW-1:0] cfg_wr_active = '0;
    logic [CW-1:0] cfg_wr_hold = '0;
    logic          in_ready;
    logic          lcd_rs;
    logic          lcd_cs_n;
    logic          lcd_wr_n;
    logic [DW-1:0] lcd_data;
    logic          lcd_oe;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int e_cs [NX];
    int e_ws [NX];
    int e_wa [NX];
    int e_wh [NX];
    logic e_rs [NX];
    logic [DW-1:0] e_d [NX];
    bit e_b2b [NX];
    int ni = 0;
    int xi = 0;
    bit last_hold = 0;
    bit mon_en = 0;

    i80_write_seq #(.DW(DW), .CW(CW)) i_i80_write_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_rs         (in_rs),
        .in_data       (in_data),
        .cfg_cs_setup  (cfg_cs_setup),
        .cfg_wr_setup  (cfg_wr_setup),
        .cfg_wr_active (cfg_wr_active),
        .cfg_wr_hold   (cfg_wr_hold),
        .lcd_rs        (lcd_rs),
        .lcd_cs_n      (lcd_cs_n),
        .lcd_wr_n      (lcd_wr_n),
        .lcd_data      (lcd_data),
        .lcd_oe        (lcd_oe),
        .busy          (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: edge distances and per-cycle levels, sampled at negedge.
    int  cyc = 0;
    int  t_busy = 0, t_csf = 0, t_wrf = 0, t_wrr = 0, t_csr = 0;
    bit  win = 0;
    logic p_busy = 0, p_cs = 1, p_wr = 1;

    always @(negedge clk) begin
        cyc++;
        if (mon_en && xi < NX) begin
            if (busy && !p_busy) begin
                t_busy = cyc;
                if (e_b2b[xi])
                    check(cyc - t_csr == 1, "R10 idle gap", cyc - t_csr, 1);
            end
            if (!lcd_cs_n && p_cs) begin
                check(cyc - t_busy == e_cs[xi] + 1, "R3 cs setup", cyc - t_busy, e_cs[xi] + 1);
                t_csf = cyc;
            end
            if (!lcd_wr_n && p_wr) begin
                check(cyc - t_csf == e_ws[xi] + 1, "R4 wr setup", cyc - t_csf, e_ws[xi] + 1);
                t_wrf = cyc;
                win = 1;
            end
            if (lcd_wr_n && !p_wr) begin
                check(cyc - t_wrf == e_wa[xi] + 1, "R5 wr active", cyc - t_wrf, e_wa[xi] + 1);
                t_wrr = cyc;
            end
            if (lcd_cs_n && !p_cs) begin
                check(cyc - t_wrr == e_wh[xi] + 1, "R6 wr hold", cyc - t_wrr, e_wh[xi] + 1);
                check(!busy, "R6 busy at release", int'(busy), 0);
                t_csr = cyc;
                win = 0;
                xi++;
            end
            if (!busy) begin
                check(lcd_cs_n && lcd_wr_n && !lcd_oe && in_ready, "R1 idle levels",
                      {lcd_cs_n, lcd_wr_n, lcd_oe, in_ready}, 4'b1101);
            end else if (xi < NX) begin
                check(!in_ready, "R2 ready while busy", int'(in_ready), 0);
                check(lcd_rs == e_rs[xi], "R8 select line", int'(lcd_rs), int'(e_rs[xi]));
                if (win) begin
                    check(lcd_oe, "R7 oe in window", int'(lcd_oe), 1);
                    check(lcd_data == e_d[xi], "R7 R9 data word", int'(lcd_data), int'(e_d[xi]));
                end else begin
                    check(!lcd_oe, "R7 oe before strobe", int'(lcd_oe), 0);
                end
            end
        end
        p_busy = busy;
        p_cs   = lcd_cs_n;
        p_wr   = lcd_wr_n;
    end

    // Present one request; scramble the inputs once it is accepted (R9).
    task automatic send(input int cs, input int ws, input int wa, input int wh, input bit hold);
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        cfg_cs_setup  = CW'(cs);
        cfg_wr_setup  = CW'(ws);
        cfg_wr_active = CW'(wa);
        cfg_wr_hold   = CW'(wh);
        in_rs         = 1'($urandom_range(1, 0));
        in_data       = DW'($urandom_range(65535, 0));
        in_valid      = 1'b1;
        e_cs[ni] = cs; e_ws[ni] = ws; e_wa[ni] = wa; e_wh[ni] = wh;
        e_rs[ni] = in_rs; e_d[ni] = in_data;
        e_b2b[ni] = last_hold;
        last_hold = hold;
        ni++;
        @(negedge clk);
        #1;
        cfg_cs_setup  = CW'($urandom_range(15, 0));
        cfg_wr_setup  = CW'($urandom_range(15, 0));
        cfg_wr_active = CW'($urandom_range(15, 0));
        cfg_wr_hold   = CW'($urandom_range(15, 0));
        in_rs         = ~in_rs;
        in_data       = ~in_data;
        if (!hold) in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(negedge clk);
            #1;
        end
        repeat (3) @(negedge clk);
        #1;
        last_hold = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && !lcd_oe && !busy && in_ready, "R1 reset state",
              {lcd_cs_n, lcd_wr_n, lcd_oe, busy, in_ready}, 5'b11001);
        #1;
        rst_n  = 1'b1;
        mon_en = 1;
        @(negedge clk);
        #1;
        // Sweep each field over its range with the others at zero.
        for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 16; v++) begin
                send(f == 0 ? v : 0, f == 1 ? v : 0, f == 2 ? v : 0, f == 3 ? v : 0, 0);
                wait_idle();
            end
        end
        send(0, 0, 0, 0, 0);
        wait_idle();
        send(15, 15, 15, 15, 0);
        wait_idle();
        send(0, 0, 1, 0, 0);
        wait_idle();
        // Random back-to-back traffic with valid held high (R10).
        for (int k = 0; k < 60; k++) begin
            send($urandom_range(15, 0), $urandom_range(15, 0),
                 $urandom_range(15, 0), $urandom_range(15, 0), k != 59);
        end
        wait_idle();
        check(xi == ni, "R2 transfer count", xi, ni);
        // Reset in the middle of the longest transfer (R1).
        mon_en = 0;
        send(15, 15, 15, 15, 0);
        repeat (20) @(negedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && !lcd_oe && !busy && in_ready, "R1 reset mid transfer",
              {lcd_cs_n, lcd_wr_n, lcd_oe, busy, in_ready}, 5'b11001);
        #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog R2 actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule